// File: doc/BRIEF.md
# Table Write Byte Lane Formatter

This block sits between a processor's byte-wide table write path and a 16-bit external memory bus. Each write request arrives as one byte of data together with a byte pointer. The block turns it into three things: a word address, a 16-bit data word, and a set of active-low write strobes and byte enables. A separate bus sequencer owns the bus cycle timing and address latching. This block only decides what appears on the two byte lanes and which strobes fire.

A 2-bit mode field selects one of three ways of writing:
- **Word-pair mode.** Writes are collected into full words. A write to an even pointer only parks the byte in a holding register. The following odd-pointer write emits the whole word with a single strobe.
- **Byte select mode.** Suits word-wide memories that take per-byte enables. One strobe is used, and a byte enable picks the lane.
- **Byte write mode.** Suits two separate byte-wide memories. The data is duplicated on both lanes, and the upper or lower strobe picks the device.

All control outputs are registered. They are asserted for exactly the one clock cycle after a request is accepted and return to their inactive level otherwise.

Top module: `tblwr_lane_fmt`

## Requirements
- R1: After reset both write strobes and both byte enables are high, the data output enable is low, the byte address bit is 0 and the word address is 0.
- R2: In the cycle after a request, the word address output equals pointer bits [PTR_W-1:1] and the byte address output equals pointer bit 0.
- R3: In word-pair mode (mode bit 1 set), a request with pointer bit 0 clear loads the byte into the holding register. It drives no data (output enable low), and both strobes and both byte enables stay high.
- R4: In word-pair mode, a request with pointer bit 0 set does the following:
  - drives the new byte on bits [15:8] and the held byte on bits [7:0], with output enable high;
  - pulls the high strobe low;
  - keeps the low strobe high;
  - pulls both byte enables low.
- R5: In byte select mode (mode 01), the byte appears on both lanes and the high strobe goes low on every request. The low strobe stays high. The upper byte enable is low for an odd pointer, and the lower byte enable is low for an even pointer.
- R6: In byte write mode (mode 00), the byte appears on both lanes and both byte enables stay high. The high strobe goes low for an odd pointer, and the low strobe goes low for an even pointer.
- R7: The low strobe is never driven low in any mode other than byte write mode.
- R8: Strobes, byte enables and output enable are asserted for exactly one cycle per request and return high/high/low in any cycle that follows a clock edge with no request.
- R9: The holding register clears on reset, so an odd-pointer word-pair write issued right after reset emits 0x00 as its lower byte.
- R10: Mode codes 10 and 11 behave identically (both are word-pair mode).
- R11: Requests in byte select or byte write mode, and odd-pointer word-pair requests, leave the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | One-cycle write request |
| wr_mode | input | 2 | Write mode: 00 byte write, 01 byte select, 1x word-pair |
| wr_ptr | input | PTR_W | Byte pointer |
| wr_byte | input | 8 | Data byte to write |
| bus_addr | output | PTR_W-1 | Word address (pointer bits above bit 0) |
| bus_data | output | 16 | Formatted data word |
| bus_data_oe | output | 1 | High when bus_data must be driven |
| byte_sel | output | 1 | Byte address bit (pointer bit 0) |
| wr_hi_n | output | 1 | Active-low high-byte write strobe |
| wr_lo_n | output | 1 | Active-low low-byte write strobe |
| ub_n | output | 1 | Active-low upper byte enable |
| lb_n | output | 1 | Active-low lower byte enable |

## Verification
The bench builds the block with its default 21-bit pointer. This makes the top pointer bit and full-width address ramps reachable, including the all-ones pointer.

The bench sweeps every one of the four mode codes, so the 11 alias of word-pair mode is exercised directly. It also covers both pointer parities and a spread of byte values that toggle every data bit. These are driven in sequences that interleave modes, which shows that only even word-pair writes reach the holding register.

Because the holding register is observable only through a later odd write, each such write carries the byte the bench expects was held. The run starts with a lone odd write straight after reset.

// File: rtl/tlf_pkg.sv
package tlf_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    WM_BYTE_WR  = 2'b00,
    WM_BYTE_SEL = 2'b01,
    WM_WORD     = 2'b10,
    WM_WORD_ALT = 2'b11
  } wmode_e;

  typedef struct packed {
    logic oe;
    logic wrh_n;
    logic wrl_n;
    logic ub_n;
    logic lb_n;
  } lane_ctl_t;

  localparam lane_ctl_t CTL_IDLE = '{oe: 1'b0, wrh_n: 1'b1, wrl_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1};

  function automatic logic is_word_mode(wmode_e m);
    return m[1];
  endfunction

  // Strobe and enable pattern for one request
  function automatic lane_ctl_t lane_ctl(wmode_e m, logic odd);
    lane_ctl_t c;
    c = CTL_IDLE;
    if (is_word_mode(m)) begin
      if (odd) begin
        c.oe = 1'b1; c.wrh_n = 1'b0; c.ub_n = 1'b0; c.lb_n = 1'b0;
      end
    end else if (m == WM_BYTE_SEL) begin
      c.oe = 1'b1; c.wrh_n = 1'b0; c.ub_n = ~odd; c.lb_n = odd;
    end else begin
      c.oe = 1'b1; c.wrh_n = ~odd; c.wrl_n = odd;
    end
    return c;
  endfunction

  // Byte placed on a given lane
  function automatic logic [BYTE_W-1:0] lane_pick(wmode_e m, int lane,
                                                  logic [BYTE_W-1:0] b,
                                                  logic [BYTE_W-1:0] held);
    if (is_word_mode(m) && lane == 0) return held;
    return b;
  endfunction

endpackage

// File: rtl/tlf_hold_reg.sv
module tlf_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/tlf_lane_decode.sv
module tlf_lane_decode
  import tlf_pkg::*;
(
  input  wmode_e                  mode,
  input  logic                    odd,
  input  logic [BYTE_W-1:0]       wbyte,
  input  logic [BYTE_W-1:0]       held,
  output logic [WORD_W-1:0]       data,
  output lane_ctl_t               ctl
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data[g*BYTE_W +: BYTE_W] = lane_pick(mode, g, wbyte, held);
  end
  assign ctl = lane_ctl(mode, odd);
endmodule

// File: rtl/tlf_out_reg.sv
module tlf_out_reg
  import tlf_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [AW-1:0]     addr_d,
  input  logic              sel_d,
  input  logic [WORD_W-1:0] data_d,
  input  lane_ctl_t         ctl_d,
  output logic [AW-1:0]     addr_q,
  output logic              sel_q,
  output logic [WORD_W-1:0] data_q,
  output lane_ctl_t         ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
      data_q <= '0;
      ctl_q  <= CTL_IDLE;
    end else if (req) begin
      addr_q <= addr_d;
      sel_q  <= sel_d;
      data_q <= data_d;
      ctl_q  <= ctl_d;
    end else begin
      ctl_q  <= CTL_IDLE;
    end
  end
endmodule

// File: rtl/tblwr_lane_fmt.sv
module tblwr_lane_fmt
  import tlf_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [1:0]         wr_mode,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic [7:0]         wr_byte,
  output logic [PTR_W-2:0]   bus_addr,
  output logic [15:0]        bus_data,
  output logic               bus_data_oe,
  output logic               byte_sel,
  output logic               wr_hi_n,
  output logic               wr_lo_n,
  output logic               ub_n,
  output logic               lb_n
);
  localparam int AW = PTR_W - 1;

  wmode_e              mode;
  logic                ptr_odd;
  logic                hold_load;
  logic [BYTE_W-1:0]   held_byte;
  logic [WORD_W-1:0]   next_data;
  lane_ctl_t           next_ctl;
  lane_ctl_t           ctl_q;

  assign mode      = wmode_e'(wr_mode);
  assign ptr_odd   = wr_ptr[0];
  assign hold_load = wr_req && is_word_mode(mode) && !ptr_odd;

  tlf_hold_reg #(.W(BYTE_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .d(wr_byte), .q(held_byte)
  );

  tlf_lane_decode dec_i (
    .mode(mode), .odd(ptr_odd), .wbyte(wr_byte), .held(held_byte),
    .data(next_data), .ctl(next_ctl)
  );

  tlf_out_reg #(.AW(AW)) out_i (
    .clk(clk), .rst_n(rst_n), .req(wr_req),
    .addr_d(wr_ptr[PTR_W-1:1]), .sel_d(ptr_odd),
    .data_d(next_data), .ctl_d(next_ctl),
    .addr_q(bus_addr), .sel_q(byte_sel), .data_q(bus_data), .ctl_q(ctl_q)
  );

  assign bus_data_oe = ctl_q.oe;
  assign wr_hi_n     = ctl_q.wrh_n;
  assign wr_lo_n     = ctl_q.wrl_n;
  assign ub_n        = ctl_q.ub_n;
  assign lb_n        = ctl_q.lb_n;
endmodule

// File: rtl/tlf_checker.sv
module tlf_checker #(
  parameter int PTR_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_req,
  input logic [1:0]       wr_mode,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             hold_load,
  input logic             bus_data_oe,
  input logic             byte_sel,
  input logic             wr_hi_n,
  input logic             wr_lo_n,
  input logic             ub_n,
  input logic             lb_n
);
  // R7
  wrl_only_bytewr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo_n |-> ($past(wr_req) && $past(wr_mode) == 2'b00));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_hi_n && !wr_lo_n));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_req) |-> (wr_hi_n && wr_lo_n && ub_n && lb_n && !bus_data_oe));

  // R2
  byte_sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_req) |-> (byte_sel == $past(wr_ptr[0])));

  // R3
  hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> (wr_hi_n && wr_lo_n && !bus_data_oe));

  // R5
  enable_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ub_n || !lb_n) |-> !wr_hi_n);
endmodule

bind tblwr_lane_fmt tlf_checker #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_mode(wr_mode), .wr_ptr(wr_ptr),
  .hold_load(hold_load), .bus_data_oe(bus_data_oe), .byte_sel(byte_sel),
  .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n), .ub_n(ub_n), .lb_n(lb_n)
);

// File: tb/tblwr_lane_fmt_tb_top.sv
module tblwr_lane_fmt_tb_top;
  localparam int PTR_W = 21;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_req = 1'b0;
  logic [1:0]       wr_mode = 2'b00;
  logic [PTR_W-1:0] wr_ptr = '0;
  logic [7:0]       wr_byte = '0;
  logic [PTR_W-2:0] bus_addr;
  logic [15:0]      bus_data;
  logic             bus_data_oe, byte_sel, wr_hi_n, wr_lo_n, ub_n, lb_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model_held = 8'h00;

  always #4 clk = ~clk;

  tblwr_lane_fmt #(.PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_mode(wr_mode), .wr_ptr(wr_ptr),
    .wr_byte(wr_byte), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_data_oe(bus_data_oe), .byte_sel(byte_sel), .wr_hi_n(wr_hi_n),
    .wr_lo_n(wr_lo_n), .ub_n(ub_n), .lb_n(lb_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One request, then check the result cycle and the idle cycle after it
  task automatic do_write(input logic [1:0] m, input logic [PTR_W-1:0] p, input logic [7:0] b);
    logic odd;
    logic [15:0] e_data;
    logic e_oe, e_wh, e_wl, e_ub, e_lb;
    string tag;
    odd = p[0];
    e_data = {b, b}; e_oe = 1; e_wh = 1; e_wl = 1; e_ub = 1; e_lb = 1;
    case (m)
      2'b00: begin tag = "R6"; e_wh = !odd; e_wl = odd; end
      2'b01: begin tag = "R5"; e_wh = 0; e_ub = !odd; e_lb = odd; end
      default: begin
        tag = (m == 2'b11) ? "R10" : (odd ? "R4" : "R3");
        if (odd) begin e_data = {b, model_held}; e_wh = 0; e_ub = 0; e_lb = 0; end
        else e_oe = 0;
      end
    endcase
    @(negedge clk);
    wr_req = 1; wr_mode = m; wr_ptr = p; wr_byte = b;
    @(negedge clk);
    wr_req = 0;
    check({tag, " oe"}, bus_data_oe, e_oe);
    check({tag, " wr_hi_n"}, wr_hi_n, e_wh);
    check({tag, " wr_lo_n (R7)"}, wr_lo_n, e_wl);
    check({tag, " ub_n"}, ub_n, e_ub);
    check({tag, " lb_n"}, lb_n, e_lb);
    if (e_oe) check({tag, " data (R11 held)"}, bus_data, e_data);
    check("R2 addr", bus_addr, p >> 1);
    check("R2 byte_sel", byte_sel, odd);
    if (m[1] && !odd) model_held = b;
    @(negedge clk);
    check("R8 idle strobes", {wr_hi_n, wr_lo_n, ub_n, lb_n, bus_data_oe}, 5'b11110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 strobes", {wr_hi_n, wr_lo_n, ub_n, lb_n}, 4'hF);
    check("R1 oe", bus_data_oe, 0);
    check("R1 byte_sel", byte_sel, 0);
    check("R1 addr", bus_addr, 0);
    rst_n = 1;
    @(negedge clk);
    // R9: lone odd word write after reset gives zero lower byte
    do_write(2'b10, 21'h000003, 8'hC3);
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 6; k++) begin
        logic [PTR_W-1:0] base;
        logic [7:0] bv;
        base = (k == 5) ? 21'h1FFFFE : 21'(k * 21'h04A6C + 21'h10000 * k);
        base[0] = 1'b0;
        bv = 8'(8'h5A ^ (k * 8'h37) ^ (m * 8'h11));
        do_write(2'(m), base, bv);
        do_write(2'(m), base | 21'h1, ~bv);
      end
    end
    // R11: non-word writes between an even and an odd word write
    do_write(2'b10, 21'h000100, 8'hA5);
    do_write(2'b01, 21'h000102, 8'h3C);
    do_write(2'b00, 21'h000104, 8'h96);
    do_write(2'b01, 21'h000105, 8'h0F);
    do_write(2'b11, 21'h000101, 8'h81);
    do_write(2'b11, 21'h000101, 8'h42);
    // Back-to-back requests without an idle cycle
    @(negedge clk);
    wr_req = 1; wr_mode = 2'b00; wr_ptr = 21'h000010; wr_byte = 8'h11;
    @(negedge clk);
    check("R6 b2b even wr_lo_n", wr_lo_n, 0);
    wr_mode = 2'b00; wr_ptr = 21'h000011; wr_byte = 8'h22;
    @(negedge clk);
    wr_req = 0;
    check("R6 b2b odd wr_hi_n", wr_hi_n, 0);
    check("R6 b2b odd wr_lo_n", wr_lo_n, 1);
    check("R6 b2b data", bus_data, 16'h2222);
    @(negedge clk);
    check("R8 b2b idle", {wr_hi_n, wr_lo_n, bus_data_oe}, 3'b110);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule